// File: doc/BRIEF.md
# RS-485 Transmit Direction Controller

This block drives the direction pin of a half-duplex RS-485 transceiver. It watches the transmit side of a UART: the transmit FIFO write strobe, the FIFO empty flag, the shift-register busy flag and the end-of-stop-bit pulse. It also watches a one-cycle baud tick. When software writes a character, the block switches the transceiver to drive. It releases the line only after the final stop bit has left, the FIFO is empty, and a programmed number of baud periods has passed.

Configuration is static during normal use. An enable bit turns the function on. An invert bit swaps the pin polarity. An 8-bit value sets the turnaround hold time in baud periods. The UART transmitter, the baud generator and the pin multiplexing sit outside this block. The direction level is its only output.

Top module: `rs485_dir_ctrl`

## Requirements
- R1: While `cfg_en` is 0 the pin stays at its idle level, and FIFO writes, end pulses and ticks have no effect.
- R2: With `cfg_en` = 1, a FIFO write puts the pin at its asserted level from the clock edge that samples the write.
- R3: With `cfg_inv` = 0, the asserted level is 0 and the idle level is 1.
- R4: With `cfg_inv` = 1, both levels are swapped: asserted is 1 and idle is 0. The invert bit acts on the pin without delay.
- R5: Transmission ends only on a `stop_done` pulse that arrives while `fifo_empty` = 1 and no write is present. A `stop_done` pulse while the FIFO still holds data leaves the pin asserted.
- R6: After the end of transmission with delay D > 0, the pin returns to idle on the edge that samples the D-th `baud_tick`. Ticks seen during sending or while idle have no effect. D may be as large as 255.
- R7: With delay 0, the pin returns to idle on the edge that samples the end of transmission.
- R8: A FIFO write during the hold time abandons the count and keeps the pin asserted. The next end of transmission reloads the full delay.
- R9: If `shifter_busy` is seen during the hold time, the block returns to the sending state and ignores ticks until the next end of transmission.
- R10: Clearing `cfg_en` while the pin is asserted returns the pin to idle in the same cycle and clears the state and the count. After re-enable the pin stays idle until a new write.
- R11: During and right after reset the block is idle, and the pin sits at the idle level for the current `cfg_inv`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_en | input | 1 | Auto direction enable |
| cfg_inv | input | 1 | Direction polarity invert |
| cfg_delay | input | 8 | Hold time after final stop bit, in baud periods |
| fifo_wr | input | 1 | Transmit FIFO write strobe |
| fifo_empty | input | 1 | Transmit FIFO empty flag |
| shifter_busy | input | 1 | Transmit shift register busy |
| stop_done | input | 1 | One-cycle pulse at the end of a stop bit |
| baud_tick | input | 1 | One-cycle pulse per baud period |
| dir_pin | output | 1 | Transceiver direction level |

## Verification
The hardest state to reach from the ports is an interrupted hold time. The count has to be partly run down and then broken off, either by a new write, by the shifter becoming busy again, or by the enable being cleared. A test that only sends and finishes shows nothing about reloading. To check reloading, the stimulus ends a frame, spends one tick, and then restarts the transmitter. It then ends the frame again and proves that the full delay is counted again: one tick after the second end, the pin is still asserted where a stale count would already have expired. The 255-period limit is reached by ending one frame and driving 255 separate ticks.

// File: rtl/rs485_dir_pkg.sv
package rs485_dir_pkg;

  localparam int DLY_W_DEF = 8;

  typedef enum logic [1:0] {
    DIR_IDLE = 2'd0,
    DIR_SEND = 2'd1,
    DIR_HOLD = 2'd2
  } dir_state_e;

  // Pin level from the internal "driving" flag and the polarity bit:
  // driving -> inv, idle -> ~inv.
  function automatic logic pin_level(input logic driving, input logic inv);
    return driving ? inv : ~inv;
  endfunction

endpackage

// File: rtl/dir_event_decode.sv
module dir_event_decode (
  input  logic en,
  input  logic fifo_wr,
  input  logic fifo_empty,
  input  logic shifter_busy,
  input  logic stop_done,
  output logic start_evt,
  output logic rearm_evt,
  output logic end_evt
);
  always_comb begin
    start_evt = en & fifo_wr;
    rearm_evt = en & (fifo_wr | shifter_busy);
    end_evt   = en & stop_done & fifo_empty & ~fifo_wr;
  end
endmodule

// File: rtl/dir_delay_counter.sv
module dir_delay_counter #(
  parameter int DLY_W = rs485_dir_pkg::DLY_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             load,
  input  logic [DLY_W-1:0] load_val,
  input  logic             count_en,
  input  logic             tick,
  output logic             expire,
  output logic             load_zero
);
  localparam logic [DLY_W-1:0] ONE = DLY_W'(1);

  logic [DLY_W-1:0] cnt_q;

  function automatic logic [DLY_W-1:0] step_down(input logic [DLY_W-1:0] v);
    return (v == '0) ? v : v - ONE;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clear)            cnt_q <= '0;
    else if (load)             cnt_q <= load_val;
    else if (count_en && tick) cnt_q <= step_down(cnt_q);
  end

  always_comb begin
    expire    = count_en & tick & (cnt_q == ONE);
    load_zero = (load_val == '0);
  end
endmodule

// File: rtl/dir_seq_fsm.sv
module dir_seq_fsm
  import rs485_dir_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       start_evt,
  input  logic       rearm_evt,
  input  logic       end_evt,
  input  logic       delay_zero,
  input  logic       expire,
  output dir_state_e state_q,
  output logic       cnt_load,
  output logic       cnt_clear
);
  dir_state_e state_d;

  always_comb begin
    state_d = state_q;
    if (!en) begin
      state_d = DIR_IDLE;
    end else begin
      unique case (state_q)
        DIR_IDLE: if (start_evt) state_d = DIR_SEND;
        DIR_SEND: if (end_evt)   state_d = delay_zero ? DIR_IDLE : DIR_HOLD;
        DIR_HOLD: begin
          if (rearm_evt)   state_d = DIR_SEND;
          else if (expire) state_d = DIR_IDLE;
        end
        default: state_d = DIR_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= DIR_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    cnt_load  = (state_q == DIR_SEND) & end_evt;
    cnt_clear = ~en | ((state_q == DIR_HOLD) & rearm_evt);
  end
endmodule

// File: rtl/dir_pin_drive.sv
module dir_pin_drive
  import rs485_dir_pkg::*;
(
  input  logic driving,
  input  logic en,
  input  logic inv,
  output logic pin
);
  always_comb pin = pin_level(driving & en, inv);
endmodule

// File: rtl/rs485_dir_ctrl.sv
module rs485_dir_ctrl
  import rs485_dir_pkg::*;
#(
  parameter int DLY_W = DLY_W_DEF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_en,
  input  logic             cfg_inv,
  input  logic [DLY_W-1:0] cfg_delay,
  input  logic             fifo_wr,
  input  logic             fifo_empty,
  input  logic             shifter_busy,
  input  logic             stop_done,
  input  logic             baud_tick,
  output logic             dir_pin
);
  logic       start_evt_w, rearm_evt_w, end_evt_w;
  logic       expire_w, delay_zero_w, cnt_load_w, cnt_clear_w;
  dir_state_e state_w;
  logic       sending_w, holding_w, driving_w;

  dir_event_decode u_dec (
    .en(cfg_en), .fifo_wr(fifo_wr), .fifo_empty(fifo_empty),
    .shifter_busy(shifter_busy), .stop_done(stop_done),
    .start_evt(start_evt_w), .rearm_evt(rearm_evt_w), .end_evt(end_evt_w)
  );

  dir_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .en(cfg_en),
    .start_evt(start_evt_w), .rearm_evt(rearm_evt_w), .end_evt(end_evt_w),
    .delay_zero(delay_zero_w), .expire(expire_w),
    .state_q(state_w), .cnt_load(cnt_load_w), .cnt_clear(cnt_clear_w)
  );

  dir_delay_counter #(.DLY_W(DLY_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clear(cnt_clear_w), .load(cnt_load_w),
    .load_val(cfg_delay), .count_en(holding_w), .tick(baud_tick),
    .expire(expire_w), .load_zero(delay_zero_w)
  );

  always_comb begin
    sending_w = (state_w == DIR_SEND);
    holding_w = (state_w == DIR_HOLD);
    driving_w = sending_w | holding_w;
  end

  dir_pin_drive u_pin (
    .driving(driving_w), .en(cfg_en), .inv(cfg_inv), .pin(dir_pin)
  );
endmodule

// File: rtl/rs485_dir_checker.sv
module rs485_dir_checker (
  input logic clk,
  input logic rst_n,
  input logic cfg_en,
  input logic cfg_inv,
  input logic fifo_wr,
  input logic shifter_busy,
  input logic baud_tick,
  input logic end_evt,
  input logic delay_zero,
  input logic sending,
  input logic holding,
  input logic dir_pin
);
  logic driving;
  always_comb driving = sending | holding;

  p_disable_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> !driving);

  p_write_asserts_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && fifo_wr) |=> driving);

  p_active_level_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && driving && !cfg_inv) |-> (dir_pin == 1'b0));

  p_hold_waits_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && holding && !baud_tick && !fifo_wr && !shifter_busy) |=> holding);

  p_zero_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sending && end_evt && delay_zero && cfg_en) |=> !driving);

  p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && holding && fifo_wr) |=> sending);

  p_idle_level_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !driving |-> (dir_pin == !cfg_inv));
endmodule

bind rs485_dir_ctrl rs485_dir_checker u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_inv(cfg_inv),
  .fifo_wr(fifo_wr), .shifter_busy(shifter_busy), .baud_tick(baud_tick),
  .end_evt(end_evt_w), .delay_zero(delay_zero_w),
  .sending(sending_w), .holding(holding_w), .dir_pin(dir_pin)
);

// File: tb/rs485_dir_ctrl_tb.sv
module rs485_dir_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1, inv = 1'b0, wr = 1'b0, empty = 1'b1, busy = 1'b0;
  logic stop = 1'b0, tick = 1'b0;
  logic [7:0] dly = 8'd2;
  logic pin;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  rs485_dir_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_en(en), .cfg_inv(inv), .cfg_delay(dly),
    .fifo_wr(wr), .fifo_empty(empty), .shifter_busy(busy),
    .stop_done(stop), .baud_tick(tick), .dir_pin(pin)
  );

  // Row bits: {en, inv, wr, empty, busy, stop, tick, expected pin}; delay 2
  localparam int NV = 19;
  localparam logic [7:0] VEC [NV] = '{
    8'b1_0_0_1_0_0_0_1, // R3 idle high
    8'b1_0_1_0_0_0_0_0, // R2 write asserts
    8'b1_0_0_1_1_0_1_0, // R6 tick while sending ignored
    8'b1_0_0_0_1_1_0_0, // R5 stop with fifo not empty
    8'b1_0_0_1_0_1_0_0, // R5 end -> hold
    8'b1_0_0_1_0_0_1_0, // R6 first tick
    8'b1_0_0_1_0_0_0_0, // R6 no tick
    8'b1_0_0_1_0_0_1_1, // R6 second tick releases
    8'b1_0_0_1_0_0_1_1, // R6 tick while idle
    8'b1_1_1_0_0_0_0_1, // R4 asserted high
    8'b1_1_0_1_0_1_0_1, // R4 hold
    8'b1_1_0_1_0_0_1_1, // R8 one tick spent
    8'b1_1_1_0_0_0_0_1, // R8 write restarts
    8'b1_1_0_1_0_0_1_1, // R8 tick ignored while sending
    8'b1_1_0_1_0_1_0_1, // R8 end again
    8'b1_1_0_1_0_0_1_1, // R8 full reload: still asserted
    8'b1_1_0_1_0_0_1_0, // R4 idle low
    8'b0_0_1_0_0_0_0_1, // R1 write ignored
    8'b0_0_0_1_0_1_1_1  // R1 end and tick ignored
  };
  localparam int VREQ [NV] = '{3,2,6,5,5,6,6,6,6,4,4,8,8,8,8,8,4,1,1};

  task automatic check(input string req, input logic exp);
    total++;
    if (pin !== exp) begin
      bad++;
      $display("FAIL %s: dir_pin=%b expected=%b", req, pin, exp);
    end
  endtask

  task automatic setin(input logic e, input logic i, input logic w,
                       input logic em, input logic b, input logic s,
                       input logic t);
    en = e; inv = i; wr = w; empty = em; busy = b; stop = s; tick = t;
  endtask

  // apply inputs at a falling edge, advance one cycle, then inputs idle
  task automatic cyc(input logic w, input logic em, input logic b,
                     input logic s, input logic t);
    wr = w; empty = em; busy = b; stop = s; tick = t;
    @(negedge clk);
    wr = 1'b0; busy = 1'b0; stop = 1'b0; tick = 1'b0; empty = 1'b1;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog: dir_pin=%b expected=finish", pin);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R11: reset state for both polarities
    @(negedge clk);
    check("R11", 1'b1);
    inv = 1'b1; #1;
    check("R11", 1'b0);
    inv = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R11", 1'b1);

    // Vector table
    dly = 8'd2;
    for (int k = 0; k < NV; k++) begin
      setin(VEC[k][7], VEC[k][6], VEC[k][5], VEC[k][4], VEC[k][3], VEC[k][2], VEC[k][1]);
      @(negedge clk);
      total++;
      if (pin !== VEC[k][0]) begin
        bad++;
        $display("FAIL R%0d row %0d: dir_pin=%b expected=%b", VREQ[k], k, pin, VEC[k][0]);
      end
    end
    setin(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    @(negedge clk);

    // R7: zero delay
    dly = 8'd0;
    cyc(1, 0, 0, 0, 0); check("R7", 1'b0);
    cyc(0, 1, 0, 1, 0); check("R7", 1'b1);

    // R9: shifter busy during hold returns to sending
    dly = 8'd2;
    cyc(1, 0, 0, 0, 0);
    cyc(0, 1, 0, 1, 0);
    cyc(0, 1, 0, 0, 1);
    cyc(0, 1, 1, 0, 0); check("R9", 1'b0);
    cyc(0, 1, 0, 0, 1);
    cyc(0, 1, 0, 0, 1);
    cyc(0, 1, 0, 0, 1); check("R9", 1'b0);
    cyc(0, 1, 0, 1, 0);
    cyc(0, 1, 0, 0, 1); check("R9", 1'b0);
    cyc(0, 1, 0, 0, 1); check("R9", 1'b1);

    // R10: disable mid-transmission
    dly = 8'd3;
    cyc(1, 0, 0, 0, 0); check("R10", 1'b0);
    en = 1'b0; #1;
    check("R10", 1'b1);
    @(negedge clk);
    en = 1'b1; #1;
    check("R10", 1'b1);
    cyc(0, 1, 0, 1, 1); check("R10", 1'b1);
    cyc(0, 1, 0, 0, 1); check("R10", 1'b1);
    // disable during hold, then a new frame counts the full delay
    cyc(1, 0, 0, 0, 0);
    cyc(0, 1, 0, 1, 0);
    cyc(0, 1, 0, 0, 1);
    en = 1'b0; @(negedge clk); en = 1'b1;
    check("R10", 1'b1);
    cyc(1, 0, 0, 0, 0);
    cyc(0, 1, 0, 1, 0);
    cyc(0, 1, 0, 0, 1);
    cyc(0, 1, 0, 0, 1); check("R10", 1'b0);
    cyc(0, 1, 0, 0, 1); check("R10", 1'b1);

    // R6: maximum delay of 255 ticks
    dly = 8'd255;
    cyc(1, 0, 0, 0, 0);
    cyc(0, 1, 0, 1, 0);
    for (int t = 0; t < 254; t++) begin
      cyc(0, 1, 0, 0, 1);
      @(negedge clk);
    end
    check("R6", 1'b0);
    cyc(0, 1, 0, 0, 1); check("R6", 1'b1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule